// File: doc/BRIEF.md
# Fused command pair sequencer

This block sits between the stage that pulls entries out of a circular submission queue and the unit that executes commands. Each incoming command carries its queue slot, opcode, an optional LBA range and a two-bit fused field. Ordinary commands pass straight through to the executor. A command marked as the first half of a fused pair is held until its partner arrives. The two are then issued to the executor back to back, as one indivisible unit, and no other command can slip in between them.

Before a pair is issued, the block checks that it is well formed. The partner must sit in the next slot, with wrap-around to slot 0. Both halves must arrive within one tail-doorbell batch. Their LBA ranges must agree when both carry one. A failure of the first half cancels the second. The block posts one completion record per command, in command order. Commands are handled one at a time. The executor reports a pass or fail result for each command it accepts.

Top module: `fused_seq`

## Requirements
- R1: A command whose fused field (dword 0, two bits) is 00 is issued once to the executor and gets one completion carrying its slot, with status 0 (success) if the executor reports pass, or 1 (execution error) if it reports fail.
- R2: A valid pair (field 01, then 10) is issued to the executor first-then-second. From the acceptance of the second until both completions are posted, `cmd_ready` stays low, so no other command is issued between them.
- R3: If the first command of a valid pair fails, the second is never issued. The completions are then first = 1 and second = 3 (aborted because the partner failed).
- R4: If only the second command of a pair fails, the first command's completion keeps the status the executor gave it (0), and the second gets 1.
- R5: When both halves carry an LBA range and the start LBA or the block count differ, neither half is issued and both complete with status 2 (invalid field). If either half carries no range, no comparison is made.
- R6: The second half must be in the slot after the first. When the first is in slot `q_last_slot`, the second must be in slot 0. Any other slot makes both halves complete with status 2, and neither is issued.
- R7: A first half that is flagged as the last entry of its doorbell batch (`cmd_batch_end`) splits the pair across two doorbell updates. Both halves then complete with status 2, and neither is issued.
- R8: A command with field 11 (reserved), or a 10 that arrives without a pending 01, is not issued and completes with status 2.
- R9: A 01 that is followed by anything other than 10 makes both commands complete with status 2, and neither is issued.
- R10: When `fuse_en` is low, any non-zero fused field completes with status 2 and is not issued. Normal commands still run.
- R11: Completions are posted in acceptance order, first half before second. Each one holds its slot and status stable until `cpl_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fuse_en | input | 1 | Enables fused pair handling |
| q_last_slot | input | SLOT_W | Index of the last slot of the queue |
| cmd_valid | input | 1 | Incoming command valid |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_slot | input | SLOT_W | Queue slot of the command |
| cmd_opc | input | OPC_W | Opcode |
| cmd_fuse | input | 2 | Fused field: 00 normal, 01 first, 10 second, 11 reserved |
| cmd_has_lba | input | 1 | Command carries an LBA range |
| cmd_slba | input | LBA_W | Start LBA |
| cmd_nlb | input | NLB_W | Block count |
| cmd_batch_end | input | 1 | Last entry covered by the current tail doorbell |
| exe_valid | output | 1 | Command offered to executor |
| exe_ready | input | 1 | Executor accepts |
| exe_slot | output | SLOT_W | Slot of issued command |
| exe_opc | output | OPC_W | Opcode of issued command |
| exe_slba | output | LBA_W | Start LBA of issued command |
| exe_nlb | output | NLB_W | Block count of issued command |
| exe_done | input | 1 | Executor result strobe |
| exe_fail | input | 1 | Result is a failure (valid with exe_done) |
| cpl_valid | output | 1 | Completion record valid |
| cpl_ready | input | 1 | Completion consumer accepts |
| cpl_slot | output | SLOT_W | Slot the completion belongs to |
| cpl_status | output | 2 | 0 ok, 1 exec error, 2 invalid field, 3 aborted |

## Verification
The hardest case to reach is an executor failure that lands on exactly one half of an otherwise valid pair. That failure is what separates cancelling the second half from leaving the first half's result alone. The bench's executor model fails a chosen slot number. Pairs are then placed so that the failing slot is either the first or the second half, and the issue log and completion log are compared. The wrap case needs a short queue, so `q_last_slot` is lowered for that scenario alone.

// File: rtl/fused_seq.sv
module fused_seq #(
  parameter int SLOT_W = 6,
  parameter int OPC_W  = 8,
  parameter int LBA_W  = 32,
  parameter int NLB_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fuse_en,
  input  logic [SLOT_W-1:0] q_last_slot,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [SLOT_W-1:0] cmd_slot,
  input  logic [OPC_W-1:0]  cmd_opc,
  input  logic [1:0]        cmd_fuse,
  input  logic              cmd_has_lba,
  input  logic [LBA_W-1:0]  cmd_slba,
  input  logic [NLB_W-1:0]  cmd_nlb,
  input  logic              cmd_batch_end,
  output logic              exe_valid,
  input  logic              exe_ready,
  output logic [SLOT_W-1:0] exe_slot,
  output logic [OPC_W-1:0]  exe_opc,
  output logic [LBA_W-1:0]  exe_slba,
  output logic [NLB_W-1:0]  exe_nlb,
  input  logic              exe_done,
  input  logic              exe_fail,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [SLOT_W-1:0] cpl_slot,
  output logic [1:0]        cpl_status
);

  localparam logic [1:0] ST_OK = 2'd0, ST_ERR = 2'd1, ST_INV = 2'd2, ST_ABT = 2'd3;
  localparam logic [1:0] F_NORM = 2'b00, F_FIRST = 2'b01, F_SECOND = 2'b10;

  typedef enum logic [2:0] {IDLE, HOLD, ISSUE1, ISSUE2, CPL} state_t;
  state_t st;

  logic [SLOT_W-1:0] a_slot, b_slot;
  logic [OPC_W-1:0]  a_opc, b_opc;
  logic [LBA_W-1:0]  a_slba, b_slba;
  logic [NLB_W-1:0]  a_nlb, b_nlb;
  logic              a_has, a_bend;
  logic [1:0]        sta, stb;
  logic              pair, inflight, cidx;

  logic              acc, lba_ok, pair_ok;
  logic [SLOT_W-1:0] next_slot;

  assign cmd_ready = (st == IDLE) || (st == HOLD);
  assign acc       = cmd_valid && cmd_ready;
  assign next_slot = (a_slot == q_last_slot) ? '0 : a_slot + 1'b1;
  assign lba_ok    = !(a_has && cmd_has_lba) || (a_slba == cmd_slba && a_nlb == cmd_nlb);
  assign pair_ok   = (cmd_fuse == F_SECOND) && (cmd_slot == next_slot) && !a_bend && lba_ok;

  assign exe_valid = ((st == ISSUE1) || (st == ISSUE2)) && !inflight;
  assign exe_slot  = (st == ISSUE2) ? b_slot : a_slot;
  assign exe_opc   = (st == ISSUE2) ? b_opc  : a_opc;
  assign exe_slba  = (st == ISSUE2) ? b_slba : a_slba;
  assign exe_nlb   = (st == ISSUE2) ? b_nlb  : a_nlb;

  assign cpl_valid  = (st == CPL);
  assign cpl_slot   = cidx ? b_slot : a_slot;
  assign cpl_status = cidx ? stb : sta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      a_slot <= '0; a_opc <= '0; a_slba <= '0; a_nlb <= '0; a_has <= 1'b0; a_bend <= 1'b0;
      b_slot <= '0; b_opc <= '0; b_slba <= '0; b_nlb <= '0;
      sta <= ST_OK; stb <= ST_OK;
      pair <= 1'b0; inflight <= 1'b0; cidx <= 1'b0;
    end else begin
      case (st)
        IDLE: if (acc) begin
          a_slot <= cmd_slot; a_opc <= cmd_opc; a_slba <= cmd_slba; a_nlb <= cmd_nlb;
          a_has <= cmd_has_lba; a_bend <= cmd_batch_end;
          pair <= 1'b0; cidx <= 1'b0;
          if (cmd_fuse == F_NORM) st <= ISSUE1;
          else if (cmd_fuse == F_FIRST && fuse_en) st <= HOLD;
          else begin sta <= ST_INV; st <= CPL; end
        end
        HOLD: if (acc) begin
          b_slot <= cmd_slot; b_opc <= cmd_opc; b_slba <= cmd_slba; b_nlb <= cmd_nlb;
          pair <= 1'b1;
          if (pair_ok) st <= ISSUE1;
          else begin sta <= ST_INV; stb <= ST_INV; st <= CPL; end
        end
        ISSUE1: begin
          if (exe_valid && exe_ready) inflight <= 1'b1;
          if (inflight && exe_done) begin
            inflight <= 1'b0;
            sta <= exe_fail ? ST_ERR : ST_OK;
            if (pair && !exe_fail) st <= ISSUE2;
            else begin
              if (pair) stb <= ST_ABT;
              st <= CPL;
            end
          end
        end
        ISSUE2: begin
          if (exe_valid && exe_ready) inflight <= 1'b1;
          if (inflight && exe_done) begin
            inflight <= 1'b0;
            stb <= exe_fail ? ST_ERR : ST_OK;
            st <= CPL;
          end
        end
        CPL: if (cpl_ready) begin
          if (!cidx && pair) cidx <= 1'b1;
          else st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  AST_NO_INTAKE_DURING_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid |-> !cmd_ready); // R2
  AST_EXE_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid && !exe_ready |=> exe_valid && $stable(exe_slot)); // R2
  AST_SECOND_CANCELLED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ISSUE1) && pair && inflight && exe_done && exe_fail |=> !exe_valid && cpl_valid); // R3
  AST_RESERVED_NOT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (st == IDLE) && (cmd_fuse == 2'b11) |=> cpl_valid && cpl_status == ST_INV); // R8
  AST_CPL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_slot) && $stable(cpl_status)); // R11

endmodule

// File: tb/test_fused_seq.sv
module test_fused_seq;
  localparam int SLOT_W = 6, OPC_W = 8, LBA_W = 32, NLB_W = 16;

  logic clk = 0, rst_n = 0, fuse_en = 1;
  logic [SLOT_W-1:0] q_last_slot = 6'd63;
  logic cmd_valid = 0, cmd_ready;
  logic [SLOT_W-1:0] cmd_slot = '0;
  logic [OPC_W-1:0] cmd_opc = '0;
  logic [1:0] cmd_fuse = '0;
  logic cmd_has_lba = 0;
  logic [LBA_W-1:0] cmd_slba = '0;
  logic [NLB_W-1:0] cmd_nlb = '0;
  logic cmd_batch_end = 0;
  logic exe_valid, exe_ready = 1;
  logic [SLOT_W-1:0] exe_slot;
  logic [OPC_W-1:0] exe_opc;
  logic [LBA_W-1:0] exe_slba;
  logic [NLB_W-1:0] exe_nlb;
  logic exe_done = 0, exe_fail = 0;
  logic cpl_valid, cpl_ready = 1;
  logic [SLOT_W-1:0] cpl_slot;
  logic [1:0] cpl_status;

  int total = 0, bad = 0;
  int fail_slot = -1;
  int iss_log [16];
  int cs_log [16];
  int ct_log [16];
  int n_iss = 0, n_cpl = 0;

  fused_seq i_fused_seq (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    exe_done <= 1'b0;
    if (exe_valid && exe_ready) begin
      if (n_iss < 16) iss_log[n_iss] = int'(exe_slot);
      n_iss++;
      exe_done <= 1'b1;
      exe_fail <= (int'(exe_slot) == fail_slot);
    end
    if (cpl_valid && cpl_ready) begin
      if (n_cpl < 16) begin cs_log[n_cpl] = int'(cpl_slot); ct_log[n_cpl] = int'(cpl_status); end
      n_cpl++;
    end
  end

  task automatic chk(input string r, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic clear();
    n_iss = 0; n_cpl = 0; fail_slot = -1;
  endtask

  task automatic send(input int s, input int f, input bit hl, input int slba, input int nlb, input bit be);
    @(negedge clk);
    cmd_slot = SLOT_W'(s); cmd_fuse = 2'(f); cmd_has_lba = hl;
    cmd_slba = LBA_W'(slba); cmd_nlb = NLB_W'(nlb); cmd_batch_end = be;
    cmd_opc = OPC_W'(s + 1); cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "reset cmd_ready", int'(cmd_ready), 1);
    chk("R1", "reset exe_valid", int'(exe_valid), 0);
    chk("R11", "reset cpl_valid", int'(cpl_valid), 0);
  endtask

  task automatic t_normal();
    clear(); fail_slot = 5;
    send(3, 0, 0, 0, 0, 1);
    send(5, 0, 0, 0, 0, 1);
    settle();
    chk("R1", "issues", n_iss, 2);
    chk("R1", "iss0", iss_log[0], 3);
    chk("R1", "cpl count", n_cpl, 2);
    chk("R1", "cpl0 slot", cs_log[0], 3);
    chk("R1", "cpl0 status", ct_log[0], 0);
    chk("R1", "cpl1 status", ct_log[1], 1);
  endtask

  task automatic t_pair();
    clear();
    send(10, 1, 1, 100, 8, 0);
    send(11, 2, 1, 100, 8, 1);
    chk("R2", "ready low after pair", int'(cmd_ready), 0);
    send(12, 0, 0, 0, 0, 1);
    settle();
    chk("R2", "issues", n_iss, 3);
    chk("R2", "iss0", iss_log[0], 10);
    chk("R2", "iss1", iss_log[1], 11);
    chk("R2", "iss2", iss_log[2], 12);
    chk("R11", "cpl count", n_cpl, 3);
    chk("R11", "cpl0 slot", cs_log[0], 10);
    chk("R11", "cpl1 slot", cs_log[1], 11);
    chk("R11", "cpl2 slot", cs_log[2], 12);
    chk("R11", "cpl1 status", ct_log[1], 0);
  endtask

  task automatic t_wrap();
    clear(); q_last_slot = 6'd15;
    send(15, 1, 0, 0, 0, 0);
    send(0, 2, 0, 0, 0, 1);
    settle();
    chk("R6", "wrap issues", n_iss, 2);
    chk("R6", "wrap iss1", iss_log[1], 0);
    chk("R6", "wrap cpl1 status", ct_log[1], 0);
    q_last_slot = 6'd63;
    clear();
    send(4, 1, 0, 0, 0, 0);
    send(6, 2, 0, 0, 0, 1);
    settle();
    chk("R6", "gap issues", n_iss, 0);
    chk("R6", "gap cpl0", ct_log[0], 2);
    chk("R6", "gap cpl1", ct_log[1], 2);
    chk("R6", "gap cpl1 slot", cs_log[1], 6);
  endtask

  task automatic t_fail_first();
    clear(); fail_slot = 20;
    send(20, 1, 0, 0, 0, 0);
    send(21, 2, 0, 0, 0, 1);
    settle();
    chk("R3", "issues", n_iss, 1);
    chk("R3", "cpl0 status", ct_log[0], 1);
    chk("R3", "cpl1 status", ct_log[1], 3);
    chk("R3", "cpl1 slot", cs_log[1], 21);
  endtask

  task automatic t_fail_second();
    clear(); fail_slot = 31;
    send(30, 1, 0, 0, 0, 0);
    send(31, 2, 0, 0, 0, 1);
    settle();
    chk("R4", "issues", n_iss, 2);
    chk("R4", "cpl0 status", ct_log[0], 0);
    chk("R4", "cpl1 status", ct_log[1], 1);
  endtask

  task automatic t_lba();
    clear();
    send(40, 1, 1, 500, 4, 0);
    send(41, 2, 1, 501, 4, 1);
    settle();
    chk("R5", "mismatch issues", n_iss, 0);
    chk("R5", "mismatch cpl0", ct_log[0], 2);
    chk("R5", "mismatch cpl1", ct_log[1], 2);
    clear();
    send(42, 1, 1, 500, 4, 0);
    send(43, 2, 0, 900, 1, 1);
    settle();
    chk("R5", "one-sided issues", n_iss, 2);
    chk("R5", "one-sided cpl1", ct_log[1], 0);
  endtask

  task automatic t_split();
    clear();
    send(50, 1, 0, 0, 0, 1);
    send(51, 2, 0, 0, 0, 1);
    settle();
    chk("R7", "split issues", n_iss, 0);
    chk("R7", "split cpl0", ct_log[0], 2);
    chk("R7", "split cpl1", ct_log[1], 2);
  endtask

  task automatic t_reserved();
    clear();
    send(7, 3, 0, 0, 0, 1);
    send(8, 2, 0, 0, 0, 1);
    settle();
    chk("R8", "issues", n_iss, 0);
    chk("R8", "cpl count", n_cpl, 2);
    chk("R8", "reserved status", ct_log[0], 2);
    chk("R8", "stray second status", ct_log[1], 2);
  endtask

  task automatic t_first_then_other();
    clear();
    send(9, 1, 0, 0, 0, 0);
    send(10, 0, 0, 0, 0, 1);
    settle();
    chk("R9", "issues", n_iss, 0);
    chk("R9", "cpl0", ct_log[0], 2);
    chk("R9", "cpl1", ct_log[1], 2);
    chk("R9", "cpl1 slot", cs_log[1], 10);
  endtask

  task automatic t_disabled();
    clear(); fuse_en = 0;
    send(12, 1, 0, 0, 0, 1);
    send(13, 0, 0, 0, 0, 1);
    settle();
    chk("R10", "issues", n_iss, 1);
    chk("R10", "first rejected", ct_log[0], 2);
    chk("R10", "normal still ok", ct_log[1], 0);
    fuse_en = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_normal();
    t_pair();
    t_wrap();
    t_fail_first();
    t_fail_second();
    t_lba();
    t_split();
    t_reserved();
    t_first_then_other();
    t_disabled();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule